// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Controller

This block gathers eight interrupt sources into one byte of sticky pending flags and turns them into a single request line for the processor. Three sources are one-cycle overflow pulses from timers inside the chip. These pulses are already synchronous, so they set their flags directly. Four sources are external pins. The last source is the output of a tone detector. These five asynchronous signals pass through a two-flop synchronizer. An edge detector then compares each synchronized level with its value one clock earlier.

Two configuration inputs choose the edge policies. The first pin can trigger on its falling edge or on its rising edge. The tone source can trigger on its falling edge only or on both edges. The other three pins trigger on a falling edge only. Software reads the flags and clears a flag by writing 0 to its bit. A separate mask byte selects which pending flags may drive the request line.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, `flag_o` is 0x00, `mask_o` is 0x00 and `irq_o` is 0. Flag bit positions are: bit0 main timer, bit1 counter1, bit2 counter2, bit3 pin 0, bit4 pin 1, bit5 pin 2, bit6 tone, bit7 pin 3. Pin k is `ext_pin_i[k]`, and the timers are `tmr_ovf_i[0..2]` in that order.
- R2: A 1 on `tmr_ovf_i[t]` during a cycle sets flag bit t at that cycle's rising clock edge.
- R3: Pin 0 sets bit3 on a falling edge when `int0_rise_sel_i` is 0, and on a rising edge when it is 1. The other edge is ignored.
- R4: Pins 1, 2 and 3 set bits 4, 5 and 7 on a falling edge only. A rising edge is ignored.
- R5: The tone input sets bit6 on a falling edge when `tone_both_sel_i` is 0, and on either edge when it is 1. With the select at 0, a rising edge is ignored.
- R6: A level change on a pin or on the tone input, applied between clock edges, shows in `flag_o` after the third following rising edge and not after the second.
- R7: Flags are sticky. A write (`flag_wr_i` = 1) clears every bit where `flag_wdata_i` is 0. A 1 in `flag_wdata_i` leaves that bit unchanged.
- R8: When a set event and a clearing write hit the same bit in the same cycle, the bit ends at 1.
- R9: A write on `mask_wr_i` loads `mask_wdata_i` into `mask_o` at the next edge. `irq_o` is 1 exactly when some bit of `flag_o & mask_o` is 1.
- R10: Changing `int0_rise_sel_i` or `tone_both_sel_i` while the inputs hold steady sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_ovf_i | input | 3 | Timer overflow pulses (main, counter1, counter2) |
| ext_pin_i | input | 4 | Asynchronous external interrupt pins 0..3 |
| tone_i | input | 1 | Asynchronous tone detector output |
| int0_rise_sel_i | input | 1 | Pin 0 edge: 0 falling, 1 rising |
| tone_both_sel_i | input | 1 | Tone edge: 0 falling only, 1 both |
| flag_wr_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 8 | Flag write data; 0 bits clear |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 8 | Mask write data |
| flag_o | output | 8 | Pending flags |
| mask_o | output | 8 | Mask register |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The assertions check four things on every cycle. A timer pulse always leaves its flag set, even against a clearing write. Flags never drop without a write, and a written 1 never drops a flag. The mask loads as written, and the request stays low when no flag or no mask bit is set. Other behaviour only the bench's scenarios can show: the per-source edge policies, the three-edge synchronizer latency, the silence of ignored edges and of select changes, and the exact bit positions.

// File: rtl/irq_flag_pkg.sv
// Package: shared sizes and flag bit positions for the interrupt flag controller.
// Assumes eight sources: three timers, four pins, one tone detector.
package irq_flag_pkg;
    localparam int NUM_SRC     = 8;
    localparam int NUM_TMR     = 3;
    localparam int NUM_PIN     = 4;
    localparam int NUM_ASYNC   = NUM_PIN + 1;
    localparam int SYNC_STAGES = 2;

    localparam int FLAG_TONE   = 6;
    localparam int ASYNC_TONE  = NUM_PIN;

    // Map an external pin index to its flag bit position.
    function automatic int pin_flag_idx(input int k);
        case (k)
            0:       return 3;
            1:       return 4;
            2:       return 5;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/irq_sync.sv
// Module: multi-bit synchronizer chain for asynchronous levels.
// Assumes each bit is an independent slow level; no bus coherence is implied.
module irq_sync #(
    parameter int   WIDTH   = 5,
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{{WIDTH{RST_VAL}}}};
        end else begin
            pipe[0] <= din;
            for (int i = 1; i < STAGES; i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/irq_edge_det.sv
// Module: single-source edge detector with run-time edge enables.
// Assumes lvl_i is already synchronous; comparison is always against the
// previous level, so changing the enables alone never produces a hit.
module irq_edge_det #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic rise_en_i,
    input  logic fall_en_i,
    output logic hit_o
);
    logic prev_q;

    // Remember the synchronized level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    // Flag a qualifying transition in the current cycle.
    always_comb begin
        hit_o = (rise_en_i &  lvl_i & ~prev_q) |
                (fall_en_i & ~lvl_i &  prev_q);
    end
endmodule

// File: rtl/irq_flag_bank.sv
// Module: sticky pending-flag register with write-zero-to-clear.
// Assumes set events have priority over a clearing write in the same cycle.
module irq_flag_bank #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] flag_o
);
    logic [WIDTH-1:0] clr_mask;

    // Bits written with 0 are the ones to clear.
    always_comb begin
        clr_mask = wr_i ? ~wdata_i : '0;
    end

    // Update flags: clear first, then let set events win.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= '0;
        else        flag_o <= (flag_o & ~clr_mask) | set_i;
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
// Module: top of the interrupt flag controller.
// Synchronizes pins and tone input, detects the configured edges, keeps the
// sticky flags and the mask, and forms the single interrupt request.
// Assumes timer pulses are synchronous to clk and one cycle wide.
module irq_flag_ctrl
    import irq_flag_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR-1:0] tmr_ovf_i,
    input  logic [NUM_PIN-1:0] ext_pin_i,
    input  logic               tone_i,
    input  logic               int0_rise_sel_i,
    input  logic               tone_both_sel_i,
    input  logic               flag_wr_i,
    input  logic [NUM_SRC-1:0] flag_wdata_i,
    input  logic               mask_wr_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    output logic [NUM_SRC-1:0] flag_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic               irq_o
);
    logic [NUM_ASYNC-1:0] async_lvl;
    logic [NUM_ASYNC-1:0] edge_hit;
    logic [NUM_SRC-1:0]   set_vec;

    irq_sync #(
        .WIDTH  (NUM_ASYNC),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({tone_i, ext_pin_i}),
        .dout (async_lvl)
    );

    // One edge detector per asynchronous source, with its own policy.
    for (genvar k = 0; k < NUM_ASYNC; k++) begin : g_edge
        logic rise_en;
        logic fall_en;
        if (k == 0) begin : g_sel_pin
            assign rise_en =  int0_rise_sel_i;
            assign fall_en = ~int0_rise_sel_i;
        end else if (k == ASYNC_TONE) begin : g_tone
            assign rise_en = tone_both_sel_i;
            assign fall_en = 1'b1;
        end else begin : g_fall_pin
            assign rise_en = 1'b0;
            assign fall_en = 1'b1;
        end
        irq_edge_det #(.RST_VAL(1'b1)) u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_i    (async_lvl[k]),
            .rise_en_i(rise_en),
            .fall_en_i(fall_en),
            .hit_o    (edge_hit[k])
        );
    end

    // Route timer pulses and edge hits to their flag positions.
    always_comb begin
        set_vec = '0;
        set_vec[NUM_TMR-1:0] = tmr_ovf_i;
        for (int k = 0; k < NUM_PIN; k++) begin
            set_vec[pin_flag_idx(k)] = edge_hit[k];
        end
        set_vec[FLAG_TONE] = edge_hit[ASYNC_TONE];
    end

    irq_flag_bank #(.WIDTH(NUM_SRC)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .wr_i   (flag_wr_i),
        .wdata_i(flag_wdata_i),
        .flag_o (flag_o)
    );

    // Hold the mask byte written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_o <= '0;
        else if (mask_wr_i) mask_o <= mask_wdata_i;
    end

    // Raise the request while any unmasked flag is pending.
    always_comb begin
        irq_o = |(flag_o & mask_o);
    end
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
// Module: cycle-level property checker for irq_flag_ctrl, bound to the top.
// Assumes the synchronous active-low reset is asserted from time zero.
module irq_flag_ctrl_chk
    import irq_flag_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_TMR-1:0] tmr_ovf_i,
    input logic               flag_wr_i,
    input logic [NUM_SRC-1:0] flag_wdata_i,
    input logic               mask_wr_i,
    input logic [NUM_SRC-1:0] mask_wdata_i,
    input logic [NUM_SRC-1:0] flag_o,
    input logic [NUM_SRC-1:0] mask_o,
    input logic               irq_o
);
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        // R2 R8
        timer_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tmr_ovf_i[t] |=> flag_o[t]);
        // R2
        timer_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_o[t]) |-> $past(tmr_ovf_i[t]));
    end

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr_i |=> ((flag_o & $past(flag_o)) == $past(flag_o)));

    // R7
    write_one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr_i |=> ((flag_o & $past(flag_o & flag_wdata_i)) == $past(flag_o & flag_wdata_i)));

    // R9
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_i |=> (mask_o == $past(mask_wdata_i)));

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |-> !irq_o);

    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o == '0) |-> !irq_o);
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (.*);

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] tmr_ovf_i = '0;
    logic [3:0] ext_pin_i = 4'hF;
    logic       tone_i = 1'b1;
    logic       int0_rise_sel_i = 1'b0;
    logic       tone_both_sel_i = 1'b0;
    logic       flag_wr_i = 1'b0;
    logic [7:0] flag_wdata_i = '0;
    logic       mask_wr_i = 1'b0;
    logic [7:0] mask_wdata_i = '0;
    logic [7:0] flag_o;
    logic [7:0] mask_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;

    irq_flag_ctrl u0 (.*);

    always #4 clk = ~clk;

    // Vector: {tmr[2:0], wr, wdata[7:0], expected flags after the edge}
    localparam int NVEC = 11;
    localparam logic [19:0] VEC [NVEC] = '{
        {3'b001, 1'b0, 8'h00, 8'h01},
        {3'b010, 1'b0, 8'h00, 8'h03},
        {3'b100, 1'b0, 8'h00, 8'h07},
        {3'b000, 1'b1, 8'hFF, 8'h07},
        {3'b000, 1'b1, 8'hFE, 8'h06},
        {3'b010, 1'b1, 8'hFD, 8'h06},
        {3'b000, 1'b1, 8'h00, 8'h00},
        {3'b101, 1'b1, 8'h00, 8'h05},
        {3'b000, 1'b0, 8'h00, 8'h05},
        {3'b000, 1'b1, 8'hFB, 8'h01},
        {3'b000, 1'b1, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        flag_wr_i = 1'b1;
        flag_wdata_i = 8'h00;
        @(negedge clk);
        flag_wr_i = 1'b0;
    endtask

    task automatic load_mask(input logic [7:0] m);
        mask_wr_i = 1'b1;
        mask_wdata_i = m;
        @(negedge clk);
        mask_wr_i = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_n(4);
        // R1: reset state
        chk("R1 flags after reset", flag_o, 8'h00);
        chk("R1 mask after reset", mask_o, 8'h00);
        chk("R1 irq after reset", irq_o, 1'b0);
        rst_n = 1'b1;
        wait_n(2);

        // Vector walk over timer sets and software writes
        for (int i = 0; i < NVEC; i++) begin
            tmr_ovf_i    = VEC[i][19:17];
            flag_wr_i    = VEC[i][16];
            flag_wdata_i = VEC[i][15:8];
            @(negedge clk);
            tmr_ovf_i = '0;
            flag_wr_i = 1'b0;
            chk($sformatf("R2/R7/R8 vector %0d", i), flag_o, VEC[i][7:0]);
        end

        // R3 R6: pin 0 falling edge with select at 0
        ext_pin_i[0] = 1'b0;
        wait_n(2);
        chk("R6 pin0 not yet after two edges", flag_o, 8'h00);
        wait_n(1);
        chk("R3 pin0 falling sets bit3", flag_o, 8'h08);
        clear_all();
        ext_pin_i[0] = 1'b1;
        wait_n(4);
        chk("R3 pin0 rising ignored in falling mode", flag_o, 8'h00);
        int0_rise_sel_i = 1'b1;
        wait_n(4);
        chk("R10 pin0 select change no set", flag_o, 8'h00);
        ext_pin_i[0] = 1'b0;
        wait_n(4);
        chk("R3 pin0 falling ignored in rising mode", flag_o, 8'h00);
        ext_pin_i[0] = 1'b1;
        wait_n(3);
        chk("R3 pin0 rising sets bit3", flag_o, 8'h08);
        clear_all();
        int0_rise_sel_i = 1'b0;
        wait_n(4);
        chk("R10 pin0 select back no set", flag_o, 8'h00);

        // R4: pins 1..3 falling only
        for (int k = 1; k < 4; k++) begin
            logic [7:0] expb;
            expb = (k == 1) ? 8'h10 : (k == 2) ? 8'h20 : 8'h80;
            ext_pin_i[k] = 1'b0;
            wait_n(3);
            chk($sformatf("R4 pin%0d falling", k), flag_o, expb);
            clear_all();
            ext_pin_i[k] = 1'b1;
            wait_n(4);
            chk($sformatf("R4 pin%0d rising ignored", k), flag_o, 8'h00);
        end

        // R5: tone edge policies
        tone_i = 1'b0;
        wait_n(3);
        chk("R5 tone falling sets bit6", flag_o, 8'h40);
        clear_all();
        tone_i = 1'b1;
        wait_n(4);
        chk("R5 tone rising ignored", flag_o, 8'h00);
        tone_both_sel_i = 1'b1;
        wait_n(4);
        chk("R10 tone select change no set", flag_o, 8'h00);
        tone_i = 1'b0;
        wait_n(3);
        chk("R5 tone falling both mode", flag_o, 8'h40);
        clear_all();
        tone_i = 1'b1;
        wait_n(2);
        chk("R6 tone not yet after two edges", flag_o, 8'h00);
        wait_n(1);
        chk("R5 tone rising both mode", flag_o, 8'h40);
        clear_all();
        tone_both_sel_i = 1'b0;

        // R9: mask and request
        tmr_ovf_i = 3'b001;
        @(negedge clk);
        tmr_ovf_i = '0;
        chk("R9 flag pending", flag_o, 8'h01);
        chk("R9 irq low with mask zero", irq_o, 1'b0);
        load_mask(8'h02);
        chk("R9 mask loaded", mask_o, 8'h02);
        chk("R9 irq low for other mask bit", irq_o, 1'b0);
        load_mask(8'h01);
        chk("R9 irq high when unmasked", irq_o, 1'b1);
        wait_n(3);
        chk("R9 irq stays high", irq_o, 1'b1);
        clear_all();
        chk("R9 irq low after clear", irq_o, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule